// File: doc/BRIEF.md
# Program-Cycle Status Read Multiplexer

This block sits on the read path of a byte-wide nonvolatile memory. While the internal program cycle runs, the stored data cannot be read. A host can still find out whether programming is over by reading the memory. During that time the block replaces the array data with a status byte, built from the last byte the host loaded and a one-bit toggle.

The status byte has three parts. The top bit is the complement of the top bit of the last loaded byte. The next bit flips once per completed read, and its first value in a new program cycle is 1. The low bits are a plain copy of the last loaded byte. When the write controller drops its busy flag, reads return the array output again.

A read is qualified when chip enable and output enable are both low (active low) and write enable is high. When no read is qualified, the output is zero. Driving the bus to high impedance is left to the pad logic.

Top module: `prog_status_rdmux`

## Requirements
- R1: A read is qualified only when `ce_n`=0, `oe_n`=0 and `we_n`=1. With no qualified read, `dout` is all zeros, whatever the value of `busy`. After reset, with no read, `dout` is 0.
- R2: During a qualified read while `busy`=1, `dout[7]` (the top bit, position DW-1) equals the complement of `last_byte[7]`.
- R3: While `busy`=1, `dout[6]` (position DW-2) takes the opposite value on each successive qualified read. The toggle advances once, at the end of each read. A read held for many clock cycles shows one steady value.
- R4: The first qualified read after `busy` rises returns `dout[6]`=1. This also holds when an earlier program cycle ended partway through a toggle sequence, and for the first cycle after reset.
- R5: During a qualified read while `busy`=1, `dout[5:0]` equals `last_byte[5:0]`.
- R6: During a qualified read while `busy`=0, `dout` equals `array_q` exactly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| busy | input | 1 | High while the internal program cycle runs |
| last_byte | input | DW (8) | Last data byte loaded by the host |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| array_q | input | DW (8) | Data read from the storage array |
| dout | output | DW (8) | Read data bus value |

## Verification
The assertions assume that `busy` and `last_byte` do not change partway through a qualified read. They also assume that each read strobe lasts at least one clock edge, so that the end of the read is seen. The stimulus meets both assumptions: it changes inputs only on the falling clock edge, holds every read for at least one full cycle, and changes `busy` and `last_byte` only while no read is active. The sweep covers every value of `last_byte`, with read counts of one to three per program cycle. It also covers all eight combinations of the control inputs with `busy` both low and high.

// File: rtl/prog_status_rdmux.sv
module prog_status_rdmux #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          busy,
  input  logic [DW-1:0] last_byte,
  input  logic          ce_n,
  input  logic          oe_n,
  input  logic          we_n,
  input  logic [DW-1:0] array_q,
  output logic [DW-1:0] dout
);
  localparam int POLL_BIT = DW - 1;
  localparam int TOG_BIT  = DW - 2;

  logic          rd, rd_q, busy_q, tog;
  logic [DW-1:0] status;

  assign rd = ~ce_n & ~oe_n & we_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q   <= 1'b0;
      busy_q <= 1'b0;
      tog    <= 1'b1;
    end else begin
      rd_q   <= rd;
      busy_q <= busy;
      if (busy && !busy_q)
        tog <= 1'b1;
      else if (busy && rd_q && !rd)
        tog <= ~tog;
    end
  end

  always_comb begin
    status           = last_byte;
    status[POLL_BIT] = ~last_byte[POLL_BIT];
    status[TOG_BIT]  = tog;
  end

  assign dout = !rd ? '0 : (busy ? status : array_q);

  // R1
  p_idle_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |-> dout == '0);
  // R2
  p_poll_inv_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && busy) |-> dout[POLL_BIT] != last_byte[POLL_BIT]);
  // R3
  p_toggle_flip_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && busy_q && rd_q && !rd) |=> tog != $past(tog));
  // R3
  p_toggle_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && rd_q && busy && busy_q) |=> $stable(tog));
  // R4
  p_first_one_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !busy_q) |=> tog);
  // R5
  p_low_copy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && busy) |-> dout[TOG_BIT-1:0] == last_byte[TOG_BIT-1:0]);
  // R6
  p_array_pass_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && !busy) |-> dout == array_q);
endmodule

// File: tb/test_prog_status_rdmux.sv
module test_prog_status_rdmux;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n, busy, ce_n, oe_n, we_n;
  logic [7:0] last_byte, array_q, dout;
  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  prog_status_rdmux #(.DW(8)) i_prog_status_rdmux (
    .clk(clk), .rst_n(rst_n), .busy(busy), .last_byte(last_byte),
    .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n), .array_q(array_q), .dout(dout)
  );

  function automatic logic [7:0] poll(input logic [7:0] v, input logic t);
    return {~v[7], t, v[5:0]};
  endfunction

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic read_check(input string tag, input logic [7:0] exp);
    @(negedge clk); ce_n = 0; oe_n = 0; we_n = 1;
    #1 check(tag, dout, exp);
    @(negedge clk); ce_n = 1; oe_n = 1;
    @(negedge clk);
  endtask

  task automatic start_prog(input logic [7:0] v);
    @(negedge clk); last_byte = v; busy = 1;
    @(negedge clk);
  endtask

  task automatic end_prog();
    @(negedge clk); busy = 0;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 0; busy = 0; ce_n = 1; oe_n = 1; we_n = 1;
    last_byte = 0; array_q = 8'h5A;
    repeat (3) @(negedge clk);
    #1 check("R1 reset idle", dout, 8'h00);
    @(negedge clk); rst_n = 1;

    // R4: first program cycle after reset
    start_prog(8'h81);
    read_check("R4 first after reset", poll(8'h81, 1'b1));
    end_prog();

    // R2 R3 R4 R5 R6: sweep every last byte value
    for (int v = 0; v < 256; v++) begin
      start_prog(v[7:0]);
      for (int k = 0; k <= v % 3; k++)
        read_check("R2/R3/R4/R5 poll", poll(v[7:0], (k % 2) == 0));
      end_prog();
      array_q = v[7:0] ^ 8'hA5;
      read_check("R6 array", v[7:0] ^ 8'hA5);
    end

    // R1: all control combinations, busy low and high
    array_q = 8'h3C;
    for (int b = 0; b < 2; b++) begin
      if (b == 1) start_prog(8'hC7);
      for (int c = 0; c < 8; c++) begin
        @(negedge clk); ce_n = c[0]; oe_n = c[1]; we_n = c[2];
        #1 begin
          logic [7:0] e;
          if (c != 4) e = 8'h00;
          else if (b == 0) e = 8'h3C;
          else e = poll(8'hC7, 1'b1);
          check("R1 strobe decode", dout, e);
        end
        @(negedge clk); ce_n = 1; oe_n = 1; we_n = 1;
        @(negedge clk);
      end
      if (b == 1) end_prog();
    end

    // R3: long read holds one value, then next read flips
    start_prog(8'h3C);
    @(negedge clk); ce_n = 0; oe_n = 0; we_n = 1;
    for (int i = 0; i < 5; i++) begin
      #1 check("R3 held read steady", dout, poll(8'h3C, 1'b1));
      @(negedge clk);
    end
    ce_n = 1; oe_n = 1;
    @(negedge clk);
    read_check("R3 flip after long read", poll(8'h3C, 1'b0));
    read_check("R3 flip back", poll(8'h3C, 1'b1));
    read_check("R3 flip again", poll(8'h3C, 1'b0));
    end_prog();

    // R4: restart after odd read count resets toggle to 1
    start_prog(8'h10);
    read_check("R4 restart seq a", poll(8'h10, 1'b1));
    end_prog();
    start_prog(8'hEF);
    read_check("R4 new cycle starts at 1", poll(8'hEF, 1'b1));
    end_prog();

    // R6: idle reads do not touch toggle; next cycle still starts at 1
    array_q = 8'h77;
    read_check("R6 idle read 1", 8'h77);
    read_check("R6 idle read 2", 8'h77);
    start_prog(8'h00);
    read_check("R4 after idle reads", poll(8'h00, 1'b1));
    end_prog();

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule